// File: doc/BRIEF.md
# Multi-Target Send Mailbox

This block is the sending side of an inter-core mailbox. Software running on the local core stages a 64-bit message in two 32-bit payload registers, selects one of up to eight destination cores with a target register, and then launches the message by writing the trigger register. Each destination has its own message slot. The slot shows its message to the remote core with a per-target valid line and a 64-bit data lane. The remote core acknowledges with a one-cycle fetch strobe. The remote ports are `tgt_valid`, `tgt_data` and `tgt_fetch`.

A single status word packs three bitfields, each indexed by target number. The busy field shows which slots still hold an unfetched message. The delivered field records fetches. The overflow field records launches that were refused because the slot was still occupied. Delivered and overflow are sticky; software clears them with a write-one-to-clear register. An interrupt status register holds three event sources: an unusable target number (block), a refused launch (overflow) and a completed fetch (delivery). A mask register gates these sources onto the single `irq` line.

The launch path is a two-state sequencer. In `S_IDLE`, an accepted trigger write snapshots the target number and payload and takes the transition `LAUNCH` into `S_ISSUE`. In `S_ISSUE`, the snapshot resolves to exactly one action: post (free slot), overflow (busy slot) or block (target number out of range). The sequencer then always takes `RETIRE` back to `S_IDLE`.

Top module: `mbx_send_inbox`

## Requirements
- R1: Reads at offset 0x00, 0x04 and 0x08 return the last value written to the target number, the low payload word and the high payload word respectively. Offset 0x1C reads back the 3-bit interrupt mask in bits 2:0.
- R2: A write to offset 0x0C with bit 0 set, accepted at clock edge k, makes the chosen free target's `tgt_valid` bit rise at edge k+1. At the same edge, that target's 64-bit lane of `tgt_data` (bits 64*t+63 to 64*t) holds {high word, low word}.
- R3: A read at offset 0x14 returns busy flags in bits 7:0, overflow flags in bits 15:8 and delivered flags in bits 23:16, with bit position within each field equal to the target number. Bits 31:24 read 0, and the busy field equals `tgt_valid`.
- R4: A `tgt_fetch` pulse on a busy target clears its busy flag, sets its delivered flag and sets interrupt status bit 2, all at that edge. A fetch on a target that is not busy changes nothing.
- R5: A launch toward a busy target sets that target's overflow flag and interrupt status bit 1. The new message is dropped, so the slot's payload and busy flag are unchanged.
- R6: A launch with a target number of 8 or more sets interrupt status bit 0 and changes no slot flag or payload.
- R7: Writing offset 0x10 clears every delivered flag whose bit is 1 in bits 23:16 of the write data and every overflow flag whose bit is 1 in bits 15:8. Busy flags are unaffected.
- R8: Writing offset 0x18 clears each interrupt status bit 2:0 written as 1 (bit 0 block, bit 1 overflow, bit 2 delivery). An event setting a bit at the same edge takes priority over the clear.
- R9: `irq` is high exactly when some interrupt status bit is set whose mask bit (offset 0x1C, same bit order) is 0. The mask resets to 3'b111.
- R10: A trigger write arriving while the sequencer is in `S_ISSUE` is ignored, so back-to-back trigger writes launch one message and raise no overflow.
- R11: After reset, all busy, delivered and overflow flags, the interrupt status and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (6) | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tgt_valid | output | NUM_TGT (8) | Per-target message pending (busy flags) |
| tgt_data | output | 64*NUM_TGT (512) | Per-target message lanes, target t at bits 64*t+63 to 64*t |
| tgt_fetch | input | NUM_TGT (8) | Per-target fetch strobe from the remote cores |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The bound checker watches these on every cycle:
- a fetched busy slot becomes not-busy and delivered on the next cycle and raises the delivery source;
- new busy or overflow flags appear only right after a cycle spent in `S_ISSUE`, at most one slot at a time;
- `S_ISSUE` never lasts two cycles;
- `irq` stays low while the status is empty.

Payload routing into the right lane, the dropped message on overflow, the register field positions, the clear-versus-set priority and the ignored second trigger can only be shown by the bench. It runs a behavioural reference model against every clock and adds directed scenarios for each of these cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int REG_W = 32;
    localparam int MSG_W = 64;
    localparam int FLD_W = 8;
    localparam int IRQ_W = 3;

    localparam int OFS_TGT  = 'h00;
    localparam int OFS_LO   = 'h04;
    localparam int OFS_HI   = 'h08;
    localparam int OFS_TRIG = 'h0C;
    localparam int OFS_FCLR = 'h10;
    localparam int OFS_STAT = 'h14;
    localparam int OFS_ISTS = 'h18;
    localparam int OFS_IMSK = 'h1C;

    localparam int IRQ_BLK = 0;
    localparam int IRQ_OVF = 1;
    localparam int IRQ_DLV = 2;

    typedef enum logic {
        S_IDLE,
        S_ISSUE
    } send_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_POST,
        ACT_OVF,
        ACT_BLOCK
    } send_act_e;
endpackage

// File: rtl/mbx_send_fsm.sv
module mbx_send_fsm
    import mbx_pkg::*;
#(
    parameter int NUM_TGT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_req,
    input  logic [REG_W-1:0]     tgt_id,
    input  logic [MSG_W-1:0]     msg_in,
    input  logic [NUM_TGT-1:0]   busy,
    output logic [NUM_TGT-1:0]   post_vec,
    output logic [NUM_TGT-1:0]   ovf_vec,
    output logic                 block_evt,
    output logic [MSG_W-1:0]     msg_out,
    output logic                 in_issue
);
    localparam int IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

    send_state_e        state, state_nx;
    send_act_e          act;
    logic [REG_W-1:0]   snap_id;
    logic [MSG_W-1:0]   snap_msg;
    logic [IDX_W-1:0]   snap_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // launch snapshot, taken on the LAUNCH transition only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_id  <= '0;
            snap_msg <= '0;
        end else if (state == S_IDLE && trig_req) begin
            snap_id  <= tgt_id;
            snap_msg <= msg_in;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (trig_req) state_nx = S_ISSUE;   // LAUNCH
            S_ISSUE: state_nx = S_IDLE;                  // RETIRE
        endcase
    end

    // outputs
    assign snap_idx = snap_id[IDX_W-1:0];

    always_comb begin
        act = ACT_NONE;
        unique case (state)
            S_IDLE:  act = ACT_NONE;
            S_ISSUE: begin
                if (snap_id >= REG_W'(NUM_TGT)) act = ACT_BLOCK;
                else if (busy[snap_idx])        act = ACT_OVF;
                else                            act = ACT_POST;
            end
        endcase
        post_vec  = (act == ACT_POST) ? (NUM_TGT'(1) << snap_idx) : '0;
        ovf_vec   = (act == ACT_OVF)  ? (NUM_TGT'(1) << snap_idx) : '0;
        block_evt = (act == ACT_BLOCK);
        in_issue  = (state == S_ISSUE);
        msg_out   = snap_msg;
    end
endmodule

// File: rtl/mbx_tgt_slot.sv
module mbx_tgt_slot
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post,
    input  logic              ovf_set,
    input  logic              fetch,
    input  logic [MSG_W-1:0]  msg,
    input  logic              dlv_clr,
    input  logic              ovf_clr,
    output logic              busy,
    output logic              dlv,
    output logic              ovf,
    output logic              dlv_evt,
    output logic [MSG_W-1:0]  payload
);
    assign dlv_evt = fetch & busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            dlv     <= 1'b0;
            ovf     <= 1'b0;
            payload <= '0;
        end else begin
            if (post)         busy <= 1'b1;
            else if (dlv_evt) busy <= 1'b0;

            if (dlv_evt)      dlv <= 1'b1;
            else if (dlv_clr) dlv <= 1'b0;

            if (ovf_set)      ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;

            if (post)         payload <= msg;
        end
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_W-1:0]  set_vec,
    input  logic              clr_wr,
    input  logic [IRQ_W-1:0]  clr_bits,
    input  logic              mask_wr,
    input  logic [IRQ_W-1:0]  mask_bits,
    output logic [IRQ_W-1:0]  sts,
    output logic [IRQ_W-1:0]  mask,
    output logic              irq
);
    logic [IRQ_W-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts  <= '0;
            mask <= '1;
        end else begin
            sts <= (sts & ~clr_eff) | set_vec;
            if (mask_wr) mask <= mask_bits;
        end
    end

    assign irq = |(sts & ~mask);
endmodule

// File: rtl/mbx_send_inbox.sv
module mbx_send_inbox
    import mbx_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int ADDR_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [REG_W-1:0]         bus_wdata,
    output logic [REG_W-1:0]         bus_rdata,
    output logic [NUM_TGT-1:0]       tgt_valid,
    output logic [NUM_TGT*MSG_W-1:0] tgt_data,
    input  logic [NUM_TGT-1:0]       tgt_fetch,
    output logic                     irq
);
    localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(OFS_TGT);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_LO);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_HI);
    localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(OFS_FCLR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_ISTS = ADDR_W'(OFS_ISTS);
    localparam logic [ADDR_W-1:0] A_IMSK = ADDR_W'(OFS_IMSK);

    logic [REG_W-1:0]   tgt_reg, lo_reg, hi_reg;
    logic               trig_req, fclr_wr, ists_wr, imsk_wr;
    logic [NUM_TGT-1:0] post_vec, ovf_vec, dlv_v, ovf_v, dlv_evt;
    logic               block_evt, in_issue;
    logic [MSG_W-1:0]   msg_out;
    logic [IRQ_W-1:0]   irq_set, irq_sts, irq_mask;

    assign trig_req = bus_wr && (bus_addr == A_TRIG) && bus_wdata[0];
    assign fclr_wr  = bus_wr && (bus_addr == A_FCLR);
    assign ists_wr  = bus_wr && (bus_addr == A_ISTS);
    assign imsk_wr  = bus_wr && (bus_addr == A_IMSK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_reg <= '0;
            lo_reg  <= '0;
            hi_reg  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_TGT) tgt_reg <= bus_wdata;
            if (bus_addr == A_LO)  lo_reg  <= bus_wdata;
            if (bus_addr == A_HI)  hi_reg  <= bus_wdata;
        end
    end

    mbx_send_fsm #(.NUM_TGT(NUM_TGT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_req  (trig_req),
        .tgt_id    (tgt_reg),
        .msg_in    ({hi_reg, lo_reg}),
        .busy      (tgt_valid),
        .post_vec  (post_vec),
        .ovf_vec   (ovf_vec),
        .block_evt (block_evt),
        .msg_out   (msg_out),
        .in_issue  (in_issue)
    );

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
        mbx_tgt_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .post    (post_vec[g]),
            .ovf_set (ovf_vec[g]),
            .fetch   (tgt_fetch[g]),
            .msg     (msg_out),
            .dlv_clr (fclr_wr & bus_wdata[2*FLD_W+g]),
            .ovf_clr (fclr_wr & bus_wdata[FLD_W+g]),
            .busy    (tgt_valid[g]),
            .dlv     (dlv_v[g]),
            .ovf     (ovf_v[g]),
            .dlv_evt (dlv_evt[g]),
            .payload (tgt_data[g*MSG_W +: MSG_W])
        );
    end

    always_comb begin
        irq_set          = '0;
        irq_set[IRQ_BLK] = block_evt;
        irq_set[IRQ_OVF] = |ovf_vec;
        irq_set[IRQ_DLV] = |dlv_evt;
    end

    mbx_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (irq_set),
        .clr_wr    (ists_wr),
        .clr_bits  (bus_wdata[IRQ_W-1:0]),
        .mask_wr   (imsk_wr),
        .mask_bits (bus_wdata[IRQ_W-1:0]),
        .sts       (irq_sts),
        .mask      (irq_mask),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_TGT:   bus_rdata = tgt_reg;
            A_LO:    bus_rdata = lo_reg;
            A_HI:    bus_rdata = hi_reg;
            A_STAT:  bus_rdata = {8'h00, FLD_W'(dlv_v), FLD_W'(ovf_v), FLD_W'(tgt_valid)};
            A_ISTS:  bus_rdata = REG_W'(irq_sts);
            A_IMSK:  bus_rdata = REG_W'(irq_mask);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_send_inbox_chk.sv
module mbx_send_inbox_chk
    import mbx_pkg::*;
#(
    parameter int NUM_TGT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_TGT-1:0] tgt_fetch,
    input logic [NUM_TGT-1:0] busy,
    input logic [NUM_TGT-1:0] dlv,
    input logic [NUM_TGT-1:0] ovf,
    input logic [IRQ_W-1:0]   irq_sts,
    input logic               irq,
    input logic               in_issue
);
    assert_fetch_clears_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        |(tgt_fetch & busy) |=> ((busy & $past(tgt_fetch & busy)) == '0)
                             && ((dlv & $past(tgt_fetch & busy)) == $past(tgt_fetch & busy)));

    assert_fetch_raises_dlv_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        |(tgt_fetch & busy) |=> irq_sts[IRQ_DLV]);

    assert_post_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy & ~$past(busy)) != '0) |-> $past(in_issue));

    assert_single_post_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy & ~$past(busy)));

    assert_ovf_after_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf & ~$past(ovf)) != '0) |-> $past(in_issue));

    assert_issue_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_issue |=> !in_issue);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sts == '0) |-> !irq);
endmodule

bind mbx_send_inbox mbx_send_inbox_chk #(.NUM_TGT(NUM_TGT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_fetch (tgt_fetch),
    .busy      (tgt_valid),
    .dlv       (dlv_v),
    .ovf       (ovf_v),
    .irq_sts   (irq_sts),
    .irq       (irq),
    .in_issue  (in_issue)
);

// File: tb/mbx_send_inbox_bench.sv
module mbx_send_inbox_bench;
    localparam int NT = 8;
    localparam int AW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NT-1:0]   tgt_valid;
    logic [NT*64-1:0] tgt_data;
    logic [NT-1:0]   tgt_fetch = '0;
    logic            irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    mbx_send_inbox u_mbx_send_inbox (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_valid(tgt_valid),
        .tgt_data(tgt_data), .tgt_fetch(tgt_fetch), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [NT-1:0] m_busy, m_dlv, m_ovf;
    logic [2:0]    m_ists, m_mask;
    logic [31:0]   m_id, m_lo, m_hi, p_id;
    logic [63:0]   p_msg;
    logic [63:0]   m_pay [NT];
    bit            m_pend;

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        case (a)
            6'h00: return m_id;
            6'h04: return m_lo;
            6'h08: return m_hi;
            6'h14: return {8'h00, m_dlv, m_ovf, m_busy};
            6'h18: return {29'd0, m_ists};
            6'h1C: return {29'd0, m_mask};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = '0; m_dlv = '0; m_ovf = '0; m_ists = '0; m_mask = 3'b111;
            m_id = '0; m_lo = '0; m_hi = '0; p_id = '0; p_msg = '0; m_pend = 0;
            for (int i = 0; i < NT; i++) m_pay[i] = '0;
        end else begin
            logic [NT-1:0] fetched, posted, ovfset;
            logic [2:0]    iset;
            bit            new_pend;
            fetched = tgt_fetch & m_busy;
            posted = '0; ovfset = '0; iset = '0; new_pend = 0;
            if (m_pend) begin
                if (p_id >= NT) iset[0] = 1'b1;
                else if (m_busy[p_id[2:0]]) begin ovfset[p_id[2:0]] = 1'b1; iset[1] = 1'b1; end
                else begin posted[p_id[2:0]] = 1'b1; m_pay[p_id[2:0]] = p_msg; end
            end
            if (fetched != '0) iset[2] = 1'b1;
            if (bus_wr) begin
                case (bus_addr)
                    6'h00: m_id = bus_wdata;
                    6'h04: m_lo = bus_wdata;
                    6'h08: m_hi = bus_wdata;
                    6'h0C: if (!m_pend && bus_wdata[0]) begin
                               new_pend = 1; p_id = m_id; p_msg = {m_hi, m_lo};
                           end
                    6'h10: begin m_dlv &= ~bus_wdata[23:16]; m_ovf &= ~bus_wdata[15:8]; end
                    6'h18: m_ists &= ~bus_wdata[2:0];
                    6'h1C: m_mask = bus_wdata[2:0];
                    default: ;
                endcase
            end
            m_busy = (m_busy & ~fetched) | posted;
            m_dlv  = m_dlv | fetched;
            m_ovf  = m_ovf | ovfset;
            m_ists = m_ists | iset;
            m_pend = new_pend;
        end
        #1;
        chk("R3 per-cycle tgt_valid vs model", 64'(tgt_valid), 64'(m_busy));
        chk("R9 per-cycle irq vs model", 64'(irq), 64'(|(m_ists & ~m_mask)));
        chk("R1 per-cycle read data vs model", 64'(bus_rdata), 64'(m_read(bus_addr)));
        for (int i = 0; i < NT; i++)
            chk("R2 per-cycle lane payload vs model", tgt_data[i*64 +: 64], m_pay[i]);
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic fetch(input int t);
        @(negedge clk);
        tgt_fetch = NT'(1) << t;
        @(negedge clk);
        tgt_fetch = '0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(6'h14, 32'h0, "R11 status after reset");
        rd(6'h18, 32'h0, "R11 interrupt status after reset");
        chk("R11 irq after reset", 64'(irq), 64'd0);
        rd(6'h1C, 32'h7, "R9 mask reset value");

        // launch to target 3
        wr(6'h04, 32'h1111_2222);
        wr(6'h08, 32'h3333_4444);
        wr(6'h00, 32'd3);
        wr(6'h0C, 32'd1);
        rd(6'h14, 32'h0000_0008, "R3 busy bit of target 3");
        chk("R2 valid of target 3", 64'(tgt_valid), 64'h08);
        chk("R2 lane 3 payload", tgt_data[3*64 +: 64], 64'h3333_4444_1111_2222);
        rd(6'h00, 32'd3, "R1 target readback");
        rd(6'h04, 32'h1111_2222, "R1 low word readback");
        rd(6'h08, 32'h3333_4444, "R1 high word readback");

        // relaunch while busy
        wr(6'h04, 32'hDEAD_BEEF);
        wr(6'h0C, 32'd1);
        rd(6'h14, 32'h0000_0808, "R5 overflow flag of target 3");
        rd(6'h18, 32'h2, "R5 overflow interrupt status");
        chk("R5 dropped message keeps lane 3", tgt_data[3*64 +: 64], 64'h3333_4444_1111_2222);
        chk("R9 masked source keeps irq low", 64'(irq), 64'd0);
        wr(6'h1C, 32'h0);
        chk("R9 unmasked source drives irq", 64'(irq), 64'd1);

        // remote fetch
        fetch(3);
        rd(6'h14, 32'h0008_0800, "R4 delivered set busy cleared");
        rd(6'h18, 32'h6, "R4 delivery interrupt status");
        fetch(0);
        rd(6'h14, 32'h0008_0800, "R4 fetch on idle target ignored");

        // out-of-range target
        wr(6'h00, 32'd9);
        wr(6'h0C, 32'd1);
        rd(6'h18, 32'h7, "R6 block interrupt status");
        rd(6'h14, 32'h0008_0800, "R6 no flag change on bad target");

        // sticky clears
        wr(6'h10, 32'h0008_0000);
        rd(6'h14, 32'h0000_0800, "R7 delivered cleared overflow kept");
        wr(6'h10, 32'h0000_FF00);
        rd(6'h14, 32'h0, "R7 overflow cleared");
        wr(6'h18, 32'h7);
        rd(6'h18, 32'h0, "R8 interrupt status cleared");
        chk("R8 irq low after clear", 64'(irq), 64'd0);

        // back-to-back triggers
        wr(6'h00, 32'd5);
        wr(6'h04, 32'h5555_0000);
        wr(6'h08, 32'h0000_5555);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'd1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        rd(6'h14, 32'h0000_0020, "R10 one launch no overflow");
        rd(6'h18, 32'h0, "R10 no overflow interrupt");
        chk("R2 lane 5 payload", tgt_data[5*64 +: 64], 64'h0000_5555_5555_0000);

        // clear and delivery in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h18; bus_wdata = 32'h7; tgt_fetch = 8'h20;
        @(negedge clk);
        bus_wr = 1'b0; tgt_fetch = '0;
        rd(6'h18, 32'h4, "R8 set wins over clear");
        rd(6'h14, 32'h0020_0000, "R4 target 5 delivered");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule